// File: doc/BRIEF.md
# Address-Masked Eight-Pin GPIO Port

This block is an eight-pin general-purpose I/O port. Software reaches it through a 32-bit register bus that uses setup and access phases. A direction register picks, pin by pin, whether the port drives the pad or listens to it. An output register holds the levels that are driven.

The data register sits behind a window of 256 word addresses. Address bits [9:2] act as a per-pin mask on both reads and writes. A single store can therefore set or clear any subset of pins without first reading the register. Pad inputs pass through a two-flop synchronizer before they can be read. The port also returns a fixed identification word at one address.

Each transfer is tracked by a small phase machine with three states: `ST_IDLE`, `ST_SETUP` and `ST_ACCESS`.
- `ST_IDLE` goes to `ST_SETUP` on select without enable, and otherwise stays in `ST_IDLE`.
- `ST_SETUP` goes to `ST_ACCESS` on select with enable, which is the only cycle in which a transfer takes effect. Any other input returns it to `ST_IDLE`.
- `ST_ACCESS` goes to `ST_SETUP` on select without enable (a back-to-back transfer), and otherwise to `ST_IDLE`.

Every transfer completes with no wait states.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every pin is an input: `gpio_oe` is 0x00, `gpio_out` is 0x00, and the direction register reads 0x00.
- R2: The direction register is at offset 0x400, bits [7:0]. A 1 in bit n makes pin n an output. `gpio_oe` shows the written value from the cycle after the write, and a read returns it.
- R3: A write to offset 0x000–0x3FC updates output bit n only when address bit n+2 is 1. Bits whose mask address bit is 0 keep their value.
- R4: A data write has no effect on the output bit of a pin whose direction bit is 0. The value takes effect only when it is written after the pin has become an output.
- R5: A read from the data window returns, in bit n, the pin level when address bit n+2 is 1, and 0 when it is 0. All bits above 7 are 0.
- R6: For an input pin, the data read returns `gpio_in` after two clock edges of synchronization.
- R7: For an output pin, the data read returns the driven output value, whatever the level on `gpio_in`.
- R8: A read from offset 0xFE0 returns the identification word 0x00041061.
- R9: Reads from any other offset return 0, and writes to them change neither `gpio_oe` nor `gpio_out`.
- R10: A transfer takes effect only in an access cycle (select and enable both high) that directly follows a setup cycle (select high, enable low). Otherwise a write is ignored and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access cycle |
| gpio_in | input | 8 | Pad input levels |
| gpio_out | output | 8 | Pad output levels |
| gpio_oe | output | 8 | Per-pin output enable |

## Verification
The masked write is tried in three forms:
- A full mask, which separates storage from masking.
- A single-pin address, which shows that the bit n+2 to pin n mapping has no offset error.
- A sparse two-bit mask, which shows that unselected pins hold their value.

The same masks are applied to reads with mixed input and output pins. This separates the synchronized pad value from the driven value, and shows that masked-out bits read as zero. Writes with inputs selected, transfers without a setup phase, and stores to unused offsets show whether a write that should be ignored leaks into the outputs.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
    localparam int unsigned PIN_W       = 8;
    localparam int unsigned ADDR_W      = 12;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned MASK_LSB    = 2;
    localparam int unsigned MASK_MSB    = MASK_LSB + PIN_W - 1;

    localparam logic [ADDR_W-1:0] DIR_OFS  = 12'h400;
    localparam logic [ADDR_W-1:0] ID_OFS   = 12'hFE0;
    localparam logic [DATA_W-1:0] ID_VALUE = 32'h0004_1061;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS
    } bus_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_mask_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic access_stb
);
    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            ST_SETUP:  state_d = (psel && penable)  ? ST_ACCESS : ST_IDLE;
            ST_ACCESS: state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        access_stb = 1'b0;
        unique case (state_q)
            ST_SETUP: access_stb = psel && penable;
            default:  access_stb = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_we,
    input  logic             data_we,
    input  logic [WIDTH-1:0] wr_val,
    input  logic [WIDTH-1:0] wr_mask,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q <= '0;
        else if (dir_we) dir_q <= wr_val;
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    out_q[i] <= 1'b0;
                else if (data_we && wr_mask[i] && dir_q[i])
                    out_q[i] <= wr_val[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [PIN_W-1:0]  gpio_in,
    output logic [PIN_W-1:0]  gpio_out,
    output logic [PIN_W-1:0]  gpio_oe
);
    logic             access_stb;
    logic             hit_data, hit_dir, hit_id;
    logic [PIN_W-1:0] mask;
    logic [PIN_W-1:0] in_sync;
    logic [PIN_W-1:0] dir_q, out_q;
    logic [PIN_W-1:0] pin_level;

    gpio_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .access_stb (access_stb)
    );

    assign hit_data = (paddr[ADDR_W-1:MASK_MSB+1] == '0);
    assign hit_dir  = (paddr == DIR_OFS);
    assign hit_id   = (paddr == ID_OFS);
    assign mask     = paddr[MASK_MSB:MASK_LSB];

    gpio_pin_regs #(.WIDTH(PIN_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_we  (access_stb && pwrite && hit_dir),
        .data_we (access_stb && pwrite && hit_data),
        .wr_val  (pwdata[PIN_W-1:0]),
        .wr_mask (mask),
        .dir_q   (dir_q),
        .out_q   (out_q)
    );

    gpio_in_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (gpio_in),
        .sync_out (in_sync)
    );

    assign pin_level = (dir_q & out_q) | (~dir_q & in_sync);

    always_comb begin
        prdata = '0;
        if (access_stb && !pwrite) begin
            if (hit_data)     prdata[PIN_W-1:0] = pin_level & mask;
            else if (hit_dir) prdata[PIN_W-1:0] = dir_q;
            else if (hit_id)  prdata = ID_VALUE;
        end
    end

    assign gpio_out = out_q;
    assign gpio_oe  = dir_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
    import gpio_mask_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] prdata,
    input logic [PIN_W-1:0]  gpio_out,
    input logic [PIN_W-1:0]  gpio_oe
);
    logic in_window, mapped, rd_acc;
    assign in_window = (paddr[ADDR_W-1:MASK_MSB+1] == '0);
    assign mapped    = in_window || (paddr == DIR_OFS) || (paddr == ID_OFS);
    assign rd_acc    = psel && penable && !pwrite;

    AST_INPUT_PIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((gpio_out ^ $past(gpio_out)) & ~$past(gpio_oe)) == '0); // R4

    AST_OUT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_out != $past(gpio_out)) |-> $past(psel && penable && pwrite)); // R3

    AST_OE_NEEDS_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_oe != $past(gpio_oe)) |-> $past(psel && penable && pwrite && paddr == DIR_OFS)); // R2

    AST_MASKED_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && in_window) |-> ((prdata & ~{{(DATA_W-PIN_W){1'b0}}, paddr[MASK_MSB:MASK_LSB]}) == '0)); // R5

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !mapped) |-> (prdata == '0)); // R9

    AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && paddr == ID_OFS && $past(psel && !penable)) |-> (prdata == ID_VALUE)); // R8
endmodule

bind gpio_mask_port gpio_mask_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .prdata   (prdata),
    .gpio_out (gpio_out),
    .gpio_oe  (gpio_oe)
);

// File: tb/gpio_mask_port_tb_top.sv
module gpio_mask_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [7:0]  gpio_in = '0;
    logic [7:0]  gpio_out, gpio_oe;
    int checks = 0, errors = 0, cycles = 0;

    always #2.5 clk = ~clk;

    gpio_mask_port dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 oe", {24'b0, gpio_oe}, 32'h0);
        check("R1 out", {24'b0, gpio_out}, 32'h0);
        bus_read(12'h400, d);
        check("R1 dir read", d, 32'h0);
    endtask

    task automatic t_dir();
        logic [31:0] d;
        bus_write(12'h400, 32'h0F);
        check("R2 oe", {24'b0, gpio_oe}, 32'h0F);
        bus_read(12'h400, d);
        check("R2 dir read", d, 32'h0F);
    endtask

    task automatic t_masked_write();
        bus_write(12'h400, 32'hFF);
        bus_write(12'h3FC, 32'hA5);
        check("R3 full mask", {24'b0, gpio_out}, 32'hA5);
        bus_write(12'h004, 32'h00);
        check("R3 single pin0", {24'b0, gpio_out}, 32'hA4);
        bus_write(12'h028, 32'hFF);
        check("R3 sparse mask", {24'b0, gpio_out}, 32'hAE);
    endtask

    task automatic t_input_discard();
        bus_write(12'h400, 32'h0F);
        bus_write(12'h3FC, 32'h00);
        check("R4 inputs held low write", {24'b0, gpio_out}, 32'hA0);
        bus_write(12'h3FC, 32'hFF);
        check("R4 inputs held high write", {24'b0, gpio_out}, 32'hAF);
        bus_write(12'h400, 32'hFF);
        check("R4 no change on dir flip", {24'b0, gpio_out}, 32'hAF);
        bus_write(12'h200, 32'h00);
        check("R4 sticks once output", {24'b0, gpio_out}, 32'h2F);
    endtask

    task automatic t_out_readback();
        logic [31:0] d;
        gpio_in = 8'h00;
        bus_read(12'h3FC, d);
        check("R7 output readback", d, 32'h2F);
    endtask

    task automatic t_sync_and_mask();
        logic [31:0] d;
        bus_write(12'h400, 32'h00);
        @(negedge clk); gpio_in = 8'h96;
        @(negedge clk); @(negedge clk);
        bus_read(12'h3FC, d);
        check("R6 synced input", d, 32'h96);
        bus_read(12'h030, d);
        check("R5 two-bit mask", d, 32'h04);
        bus_read(12'h008, d);
        check("R5 pin1 high", d, 32'h02);
        bus_read(12'h004, d);
        check("R5 pin0 low", d, 32'h00);
        bus_write(12'h400, 32'hF0);
        bus_read(12'h3FC, d);
        check("R7 mixed pins", d, 32'h26);
    endtask

    task automatic t_id();
        logic [31:0] d;
        bus_read(12'hFE0, d);
        check("R8 id word", d, 32'h0004_1061);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_read(12'h404, d);
        check("R9 unmapped read", d, 32'h0);
        bus_write(12'h408, 32'hFF);
        bus_write(12'h800, 32'h00);
        check("R9 oe untouched", {24'b0, gpio_oe}, 32'hF0);
        check("R9 out untouched", {24'b0, gpio_out}, 32'h2F);
    endtask

    task automatic t_no_setup();
        logic [31:0] d;
        @(negedge clk); psel = 1; penable = 1; pwrite = 1; paddr = 12'h400; pwdata = 32'h55;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        check("R10 write without setup", {24'b0, gpio_oe}, 32'hF0);
        @(negedge clk); psel = 1; penable = 1; pwrite = 0; paddr = 12'hFE0;
        #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
        check("R10 read without setup", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir();
        t_masked_write();
        t_input_discard();
        t_out_readback();
        t_sync_and_mask();
        t_id();
        t_unmapped();
        t_no_setup();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule